// File: doc/BRIEF.md
# Dual-Clock Mailbox Register

This block moves a single data word from a writer running on one clock to a reader running on an unrelated clock. It is a side channel, separate from any bulk queue. The writer stores a word by raising its mailbox select and write enable together on a rising edge of its clock. The reader sees a full flag in its own clock domain. It collects the word on a 36-bit output bus, and a strobe with select lowers the flag.

The writer's data path can be 18 bits wide or 9 bits wide. The `cfg_byte` input picks the width. It is taken only while the write-side reset is held. In 9-bit mode the upper input bits play no part.

A toggle handshake crosses the clock boundary. A toggle for a new word goes to the reader through a two-flop synchronizer, and a toggle for each acknowledgement comes back the same way. The writer treats the mailbox as occupied from its own write until the acknowledgement returns. Any write in that window is dropped, so a word that has not been read is never overwritten. A read does not clear the word, which stays on the output until the next word arrives.

Top module: `mbox_xfer`

## Requirements
- R1: In 18-bit mode (`cfg_byte` low during reset), an accepted write stores all of `wdata[17:0]`. When the flag rises, `rdata[17:0]` equals that word and `rdata[35:18]` is zero.
- R2: In 9-bit mode (`cfg_byte` high during reset), only `wdata[8:0]` is stored. `wdata[17:9]` is ignored, and `rdata[35:9]` reads zero.
- R3: A write happens only on a rising `wclk` edge where `wsel` and `wen` are both high. With either one low, nothing is stored and `mbx_full` stays low.
- R4: After an accepted write, `mbx_full` rises within 8 `rclk` cycles, and `rdata` holds the new word from that same edge on.
- R5: `mbx_full` stays high until a rising `rclk` edge where `rsel` and `rstrb` are both high. It is low after that edge. A strobe without select leaves it high.
- R6: A read does not change `rdata`. The last word remains visible after the flag has dropped.
- R7: A write made while the mailbox is still occupied is discarded. It does not change `rdata` and does not set the flag again after the read.
- R8: The width mode is latched only while `wrst_n` is low. Changes on `cfg_byte` after reset have no effect.
- R9: After reset, `mbx_full` is low and `rdata` is zero.
- R10: A write issued 8 `wclk` cycles after a read is accepted and delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Writer clock |
| wrst_n | input | 1 | Writer synchronous reset, active low |
| cfg_byte | input | 1 | 1 selects 9-bit writes, sampled during reset |
| wsel | input | 1 | Writer mailbox select |
| wen | input | 1 | Writer write enable |
| wdata | input | 18 | Writer data |
| rclk | input | 1 | Reader clock |
| rrst_n | input | 1 | Reader synchronous reset, active low |
| rsel | input | 1 | Reader mailbox select |
| rstrb | input | 1 | Reader read strobe |
| rdata | output | 36 | Mailbox word, zero-extended |
| mbx_full | output | 1 | New word waiting for the reader |

## Verification
The bench writes a second word while the first is still unread. A design that lets this write through would show the wrong word or raise the flag a second time. It changes `cfg_byte` after reset. A design that keeps sampling the mode would then truncate or widen the data. In 9-bit mode it drives patterns with the upper bits set, which shows up an input mask that is missing. It also gives a strobe without select, or a select without enable, which shows up a qualifier that is missing. Last, it issues a write soon after a read, which would stall if the acknowledgement never crossed back.

// File: rtl/mbox_pkg.sv
// Package: shared width mode type and input masking for the mailbox.
// Assumes WR_W >= BYTE_W.
package mbox_pkg;
    typedef enum logic {
        MODE_WORD = 1'b0,
        MODE_BYTE = 1'b1
    } mbox_mode_e;

    // Keep only the low BYTE_W bits when the writer is narrow.
    function automatic logic [17:0] mask_word(input logic [17:0] d,
                                              input mbox_mode_e  m,
                                              input int          byte_w);
        logic [17:0] r;
        for (int i = 0; i < 18; i++) begin
            r[i] = (m == MODE_BYTE && i >= byte_w) ? 1'b0 : d[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/mbox_sync.sv
// Multi-flop level synchronizer for a single control bit.
// Assumes the input changes no more often than once per few destination cycles.
module mbox_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Each stage samples the previous stage (the first one samples d).
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= d;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_wr.sv
// Writer side: latches the width mode during reset, accepts one word at a time,
// and flips a toggle per accepted word. Assumes ack_tog_s is already synchronized.
module mbox_wr
    import mbox_pkg::*;
#(
    parameter int WR_W   = 18,
    parameter int BYTE_W = 9
) (
    input  logic            wclk,
    input  logic            wrst_n,
    input  logic            cfg_byte,
    input  logic            wsel,
    input  logic            wen,
    input  logic [WR_W-1:0] wdata,
    input  logic            ack_tog_s,
    output logic [WR_W-1:0] store_q,
    output logic            put_tog,
    output logic            busy,
    output mbox_mode_e      mode_q
);
    logic accept;

    assign busy   = put_tog ^ ack_tog_s;
    assign accept = wsel & wen & ~busy;

    // Mode register: follows cfg_byte only while reset is held.
    always_ff @(posedge wclk) begin
        if (!wrst_n) mode_q <= cfg_byte ? MODE_BYTE : MODE_WORD;
    end

    // Data register and toggle: update on each accepted write.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            store_q <= '0;
            put_tog <= 1'b0;
        end else if (accept) begin
            store_q <= WR_W'(mask_word(18'(wdata), mode_q, BYTE_W));
            put_tog <= ~put_tog;
        end
    end
endmodule

// File: rtl/mbox_rd.sv
// Reader side: detects a new toggle, captures the stable word, raises the flag,
// and returns an acknowledge toggle on a qualified read. Assumes put_tog_s is synchronized.
module mbox_rd #(
    parameter int WR_W  = 18,
    parameter int RD_W  = 36
) (
    input  logic            rclk,
    input  logic            rrst_n,
    input  logic            rsel,
    input  logic            rstrb,
    input  logic [WR_W-1:0] store_q,
    input  logic            put_tog_s,
    output logic [RD_W-1:0] rdata,
    output logic            full_q,
    output logic            ack_tog
);
    logic seen_tog;
    logic arrive;
    logic take;

    assign arrive = put_tog_s ^ seen_tog;
    assign take   = full_q & rsel & rstrb;

    // Capture register: loads the word once its toggle has crossed over.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rdata    <= '0;
            seen_tog <= 1'b0;
        end else if (arrive) begin
            rdata    <= RD_W'(store_q);
            seen_tog <= put_tog_s;
        end
    end

    // Flag and acknowledge: set on arrival, cleared and acknowledged on a read.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            full_q  <= 1'b0;
            ack_tog <= 1'b0;
        end else if (arrive) begin
            full_q <= 1'b1;
        end else if (take) begin
            full_q  <= 1'b0;
            ack_tog <= ~ack_tog;
        end
    end
endmodule

// File: rtl/mbox_xfer.sv
// Top: single-word mailbox between two clock domains, joined by toggle handshakes
// through SYNC_STAGES-flop synchronizers in each direction.
module mbox_xfer
    import mbox_pkg::*;
#(
    parameter int WR_W        = 18,
    parameter int BYTE_W      = 9,
    parameter int RD_W        = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic            wclk,
    input  logic            wrst_n,
    input  logic            cfg_byte,
    input  logic            wsel,
    input  logic            wen,
    input  logic [WR_W-1:0] wdata,
    input  logic            rclk,
    input  logic            rrst_n,
    input  logic            rsel,
    input  logic            rstrb,
    output logic [RD_W-1:0] rdata,
    output logic            mbx_full
);
    logic [WR_W-1:0] w_store;
    logic            w_tog;
    logic            w_busy;
    mbox_mode_e      w_mode;
    logic            ack_tog;
    logic            ack_tog_s;
    logic            w_tog_s;

    mbox_wr #(.WR_W(WR_W), .BYTE_W(BYTE_W)) u_wr (
        .wclk(wclk), .wrst_n(wrst_n), .cfg_byte(cfg_byte),
        .wsel(wsel), .wen(wen), .wdata(wdata),
        .ack_tog_s(ack_tog_s), .store_q(w_store), .put_tog(w_tog),
        .busy(w_busy), .mode_q(w_mode)
    );

    mbox_sync #(.STAGES(SYNC_STAGES)) u_put_sync (
        .clk(rclk), .rst_n(rrst_n), .d(w_tog), .q(w_tog_s)
    );

    mbox_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(wclk), .rst_n(wrst_n), .d(ack_tog), .q(ack_tog_s)
    );

    mbox_rd #(.WR_W(WR_W), .RD_W(RD_W)) u_rd (
        .rclk(rclk), .rrst_n(rrst_n), .rsel(rsel), .rstrb(rstrb),
        .store_q(w_store), .put_tog_s(w_tog_s),
        .rdata(rdata), .full_q(mbx_full), .ack_tog(ack_tog)
    );
endmodule

// File: rtl/mbox_xfer_chk.sv
// Checker: temporal properties of the mailbox, bound onto mbox_xfer.
module mbox_xfer_chk #(
    parameter int WR_W   = 18,
    parameter int BYTE_W = 9,
    parameter int RD_W   = 36
) (
    input logic            wclk,
    input logic            wrst_n,
    input logic            rclk,
    input logic            rrst_n,
    input logic            wsel,
    input logic            wen,
    input logic            rsel,
    input logic            rstrb,
    input logic            mbx_full,
    input logic [RD_W-1:0] rdata,
    input logic            w_busy,
    input logic [WR_W-1:0] w_store,
    input logic            w_mode
);
    a_r2_byte_upper_clear: assert property (@(posedge wclk) disable iff (!wrst_n)
        w_mode |-> (w_store[WR_W-1:BYTE_W] == '0));

    a_r8_mode_frozen: assert property (@(posedge wclk) disable iff (!wrst_n)
        $stable(w_mode));

    a_r7_no_overwrite: assert property (@(posedge wclk) disable iff (!wrst_n)
        (w_busy && wsel && wen) |=> $stable(w_store));

    a_r5_clear_on_read: assert property (@(posedge rclk) disable iff (!rrst_n)
        (mbx_full && rsel && rstrb) |=> !mbx_full);

    a_r5_hold_until_read: assert property (@(posedge rclk) disable iff (!rrst_n)
        (mbx_full && !(rsel && rstrb)) |=> mbx_full);

    a_r6_read_keeps_data: assert property (@(posedge rclk) disable iff (!rrst_n)
        (mbx_full && rsel && rstrb) |=> $stable(rdata));
endmodule

bind mbox_xfer mbox_xfer_chk #(.WR_W(WR_W), .BYTE_W(BYTE_W), .RD_W(RD_W)) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .wsel(wsel), .wen(wen), .rsel(rsel), .rstrb(rstrb),
    .mbx_full(mbx_full), .rdata(rdata), .w_busy(w_busy),
    .w_store(w_store), .w_mode(w_mode)
);

// File: tb/mbox_xfer_bench.sv
module mbox_xfer_bench;
    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        wrst_n = 1'b0;
    logic        rrst_n = 1'b0;
    logic        cfg_byte = 1'b0;
    logic        wsel = 1'b0;
    logic        wen = 1'b0;
    logic [17:0] wdata = '0;
    logic        rsel = 1'b0;
    logic        rstrb = 1'b0;
    logic [35:0] rdata;
    logic        mbx_full;

    int checks = 0;
    int errors = 0;
    bit byte_mode = 1'b0;
    bit seen = 1'b0;
    logic [17:0] exp_q[$];

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    mbox_xfer u_mbox_xfer (
        .wclk(wclk), .wrst_n(wrst_n), .cfg_byte(cfg_byte),
        .wsel(wsel), .wen(wen), .wdata(wdata),
        .rclk(rclk), .rrst_n(rrst_n), .rsel(rsel), .rstrb(rstrb),
        .rdata(rdata), .mbx_full(mbx_full)
    );

    task automatic check(input bit ok, input string req,
                         input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one write cycle; push the expected word if it should be accepted.
    task automatic mb_write(input logic [17:0] d, input bit s, input bit e, input bit expect_ok);
        @(negedge wclk);
        wsel = s; wen = e; wdata = d;
        @(negedge wclk);
        wsel = 1'b0; wen = 1'b0; wdata = '0;
        if (expect_ok) exp_q.push_back(byte_mode ? (d & 18'h001FF) : d);
    endtask

    task automatic mb_read(input bit s);
        @(negedge rclk);
        rsel = s; rstrb = 1'b1;
        @(negedge rclk);
        rsel = 1'b0; rstrb = 1'b0;
    endtask

    task automatic wait_full(input string req);
        int n;
        n = 0;
        while (!mbx_full && n < 8) begin
            @(negedge rclk);
            n++;
        end
        check(mbx_full === 1'b1, req, {35'd0, mbx_full}, 36'd1);
    endtask

    task automatic do_reset(input bit m);
        wrst_n = 1'b0; rrst_n = 1'b0; cfg_byte = m;
        repeat (6) @(negedge wclk);
        wrst_n = 1'b1; rrst_n = 1'b1;
        byte_mode = m;
        @(negedge rclk);
        check(mbx_full === 1'b0, "R9 flag", {35'd0, mbx_full}, 36'd0);
        check(rdata === 36'd0, "R9 data", rdata, 36'd0);
    endtask

    // Monitor: on each flag rise compare the captured word with the scoreboard.
    always @(negedge rclk) begin
        if (!rrst_n) begin
            seen = 1'b0;
        end else if (mbx_full && !seen) begin
            seen = 1'b1;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R7 unexpected word", rdata, 36'd0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                check(rdata === {18'd0, e}, byte_mode ? "R2 word" : "R1 word",
                      rdata, {18'd0, e});
            end
        end else if (!mbx_full) begin
            seen = 1'b0;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge wclk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [35:0] held;

        // 18-bit mode
        do_reset(1'b0);

        // R3: select without enable, enable without select
        mb_write(18'h15555, 1'b1, 1'b0, 1'b0);
        mb_write(18'h0AAAA, 1'b0, 1'b1, 1'b0);
        repeat (8) @(negedge rclk);
        check(mbx_full === 1'b0, "R3 no write", {35'd0, mbx_full}, 36'd0);

        // R1, R4: full word delivered
        mb_write(18'h2B3C4, 1'b1, 1'b1, 1'b1);
        wait_full("R4 flag rise");

        // R5: strobe without select is ignored
        mb_read(1'b0);
        check(mbx_full === 1'b1, "R5 strobe without select", {35'd0, mbx_full}, 36'd1);

        // R7: write while still occupied is dropped
        mb_write(18'h11111, 1'b1, 1'b1, 1'b0);
        mb_read(1'b1);
        check(mbx_full === 1'b0, "R5 clear on read", {35'd0, mbx_full}, 36'd0);
        check(rdata === 36'h002B3C4, "R6 data after read", rdata, 36'h002B3C4);
        repeat (10) @(negedge rclk);
        check(mbx_full === 1'b0, "R7 dropped write no flag", {35'd0, mbx_full}, 36'd0);
        check(rdata === 36'h002B3C4, "R7 dropped write no data", rdata, 36'h002B3C4);

        // R10: next write after acknowledge returns
        repeat (8) @(negedge wclk);
        mb_write(18'h3FFFF, 1'b1, 1'b1, 1'b1);
        wait_full("R10 flag rise");
        mb_read(1'b1);

        // R8: cfg change after reset ignored (still 18-bit)
        cfg_byte = 1'b1;
        repeat (8) @(negedge wclk);
        mb_write(18'h3FE01, 1'b1, 1'b1, 1'b1);
        wait_full("R8 flag rise");
        held = rdata;
        check(held === 36'h003FE01, "R8 word mode kept", held, 36'h003FE01);
        mb_read(1'b1);

        // 9-bit mode
        do_reset(1'b1);
        mb_write(18'h3FEA5, 1'b1, 1'b1, 1'b1);
        wait_full("R4 flag rise byte");
        check(rdata[35:9] === 27'd0, "R2 upper bits", rdata, {27'd0, rdata[8:0]});
        mb_read(1'b1);

        cfg_byte = 1'b0;
        repeat (8) @(negedge wclk);
        mb_write(18'h2AB5C, 1'b1, 1'b1, 1'b1);
        wait_full("R8 flag rise byte");
        check(rdata === 36'h00000015C, "R8 byte mode kept", rdata, 36'h00000015C);
        mb_read(1'b1);
        check(rdata === 36'h00000015C, "R6 byte data after read", rdata, 36'h00000015C);

        repeat (10) @(negedge rclk);
        check(exp_q.size() == 0, "R4 all words delivered", 36'(exp_q.size()), 36'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule